// File: doc/BRIEF.md
# DDR Read Receive-Enable Window Timer

This block opens the receive-enable window of a DDR3 read data path, so that incoming data strobes are only observed while valid strobe edges are expected. Each accepted read command places a window on a half-cycle time line. The coarse part of the start point is the CAS latency minus one cycle, which leaves the read preamble inside the window. A programmable number of half-cycles is added to that base. The window is four clock cycles long, which fits a burst of eight. The window is driven out as two registered half-cycle enables: one for the first half of each clock period and one for the second half. A downstream merge stage combines them onto the strobe gate.

A 32-bit gating control word carries the half-cycle count in bits [27:24] and a fine offset in 1/256-cycle steps in bits [22:16]. The total programmed delay is (half-cycle count × 0.5 cycle) + (fine offset / 256 × 1 cycle). The fine offset is not applied here. It is captured with each read and passed to an external delay line. Half-cycle counts 14 and 15 are not legal. When one is programmed, the block uses count 13 in its place and raises a sticky configuration-error flag. A read that arrives while earlier windows are still pending gets a window of its own, so back-to-back reads are fully supported.

Top module: `ddr_rd_gate_timer`

## Requirements
- R1: The half-cycle count is read from bits [27:24] of `gate_ctrl` and the fine offset from bits [22:16]. No other bit of the word affects any output.
- R2: Let edge 0 be the rising edge that samples `rd_cmd`=1. The outputs present after edge c describe half-cycle slots 2c (`gate_even`) and 2c+1 (`gate_odd`) relative to edge 0. The first enabled slot is s = 2×max(`cas_lat`−1, 0) + half-cycle count.
- R3: Each read enables exactly 8 consecutive half-cycle slots, s through s+7 (4 clock cycles).
- R4: A half-cycle count of 14 or 15 is treated as 13 when computing the window of that read.
- R5: `cfg_err` goes to 1 after any rising edge at which `gate_ctrl` carries a half-cycle count of 14 or 15. Once set, it stays at 1 until reset.
- R6: Reads in consecutive or nearby cycles each produce their own window. When windows overlap, the enables are their union.
- R7: On each accepted read, `fine_code` takes the fine offset of that cycle's `gate_ctrl` after the same edge.
- R8: Synchronous active-high `rst` clears both enables, `fine_code` and `cfg_err`, and discards every pending window.
- R9: Without `rd_cmd`, changes to `gate_ctrl` or `cas_lat` open no window and leave `fine_code` unchanged.
- R10: A `cas_lat` of 0 or 1 gives a base of zero cycles. With a half-cycle count of 0, `gate_even` is then asserted right after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_cmd | input | 1 | Read command accepted at this edge |
| cas_lat | input | 4 | CAS latency in clock cycles |
| gate_ctrl | input | 32 | Gating control word (half-cycle count, fine offset) |
| gate_even | output | 1 | Receive enable for the first half of the current cycle |
| gate_odd | output | 1 | Receive enable for the second half of the current cycle |
| fine_code | output | 7 | Fine delay code for the external delay line |
| cfg_err | output | 1 | Sticky flag: reserved half-cycle count seen |

## Verification
Isolated single reads are tried over both odd and even half-cycle counts and the lowest CAS latencies. This separates a wrong base subtraction from a wrong phase choice or a wrong window length. Back-to-back reads with different settings show whether overlapping windows merge rather than overwrite each other. Reserved counts show the clamp and the sticky flag. A reset in the middle of a window shows that pending work is dropped. Long runs with random commands, latencies and control words, including random bits outside the two fields, are compared slot by slot against a window list kept by the bench.

// File: rtl/ddr_gate_pkg.sv
package ddr_gate_pkg;
  localparam int CTRL_W        = 32;
  localparam int SLOTS_PER_CYC = 2;

  // Round a slot count up to a whole number of clock cycles.
  function automatic int even_up(input int v);
    return v + (v % SLOTS_PER_CYC);
  endfunction
endpackage

// File: rtl/ddr_gate_decode.sv
module ddr_gate_decode #(
  parameter int CL_W         = 4,
  parameter int HC_W         = 4,
  parameter int HC_LEGAL_MAX = 13,
  parameter int SLOT_W       = 6
) (
  input  logic [CL_W-1:0]   cas_lat,
  input  logic [HC_W-1:0]   hc_code,
  output logic [SLOT_W-1:0] start_slot,
  output logic              reserved
);
  logic [HC_W-1:0]   hc_eff;
  logic [SLOT_W-1:0] base_cyc;

  always_comb begin
    reserved = (int'(hc_code) > HC_LEGAL_MAX);
    hc_eff   = reserved ? HC_W'(HC_LEGAL_MAX) : hc_code;
    // preamble: strobe leaves high-Z one cycle before CAS latency
    base_cyc = (cas_lat == '0) ? '0 : (SLOT_W'(cas_lat) - SLOT_W'(1));
    start_slot = (base_cyc << 1) + SLOT_W'(hc_eff);
  end
endmodule

// File: rtl/ddr_gate_wheel.sv
module ddr_gate_wheel
  import ddr_gate_pkg::*;
#(
  parameter int WHEEL_W     = 50,
  parameter int SLOT_W      = 6,
  parameter int BURST_SLOTS = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [SLOT_W-1:0]        start_slot,
  output logic [SLOTS_PER_CYC-1:0] cur_slots
);
  logic [WHEEL_W-1:0] wheel_q;
  logic [WHEEL_W-1:0] new_win;

  // Window mask: slots start_slot .. start_slot+BURST_SLOTS-1
  always_comb begin
    for (int j = 0; j < WHEEL_W; j++) begin
      new_win[j] = (j >= int'(start_slot)) && (j < int'(start_slot) + BURST_SLOTS);
    end
  end

  // Bit j of the wheel is the slot j half-cycles from the current cycle start.
  always_ff @(posedge clk) begin
    if (rst) begin
      wheel_q <= '0;
    end else begin
      wheel_q <= (wheel_q >> SLOTS_PER_CYC) | (load ? new_win : '0);
    end
  end

  assign cur_slots = wheel_q[SLOTS_PER_CYC-1:0];
endmodule

// File: rtl/ddr_rd_gate_timer.sv
module ddr_rd_gate_timer
  import ddr_gate_pkg::*;
#(
  parameter int CL_W         = 4,
  parameter int HC_W         = 4,
  parameter int FINE_W       = 7,
  parameter int HC_LSB       = 24,
  parameter int FINE_LSB     = 16,
  parameter int HC_LEGAL_MAX = 13,
  parameter int BURST_CYC    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_cmd,
  input  logic [CL_W-1:0]   cas_lat,
  input  logic [CTRL_W-1:0] gate_ctrl,
  output logic              gate_even,
  output logic              gate_odd,
  output logic [FINE_W-1:0] fine_code,
  output logic              cfg_err
);
  localparam int BURST_SLOTS = BURST_CYC * SLOTS_PER_CYC;
  localparam int MAX_BASE    = (1 << CL_W) - 2;
  localparam int WHEEL_W     = even_up(SLOTS_PER_CYC * MAX_BASE + HC_LEGAL_MAX + BURST_SLOTS);
  localparam int SLOT_W      = $clog2(WHEEL_W);

  logic [HC_W-1:0]          hc_field;
  logic [FINE_W-1:0]        fine_field;
  logic [SLOT_W-1:0]        start_slot;
  logic                     hc_reserved;
  logic [SLOTS_PER_CYC-1:0] cur_slots;

  assign hc_field   = gate_ctrl[HC_LSB +: HC_W];
  assign fine_field = gate_ctrl[FINE_LSB +: FINE_W];

  ddr_gate_decode #(
    .CL_W(CL_W), .HC_W(HC_W), .HC_LEGAL_MAX(HC_LEGAL_MAX), .SLOT_W(SLOT_W)
  ) u_dec (
    .cas_lat    (cas_lat),
    .hc_code    (hc_field),
    .start_slot (start_slot),
    .reserved   (hc_reserved)
  );

  ddr_gate_wheel #(
    .WHEEL_W(WHEEL_W), .SLOT_W(SLOT_W), .BURST_SLOTS(BURST_SLOTS)
  ) u_wheel (
    .clk        (clk),
    .rst        (rst),
    .load       (rd_cmd),
    .start_slot (start_slot),
    .cur_slots  (cur_slots)
  );

  assign gate_even = cur_slots[0];
  assign gate_odd  = cur_slots[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      fine_code <= '0;
      cfg_err   <= 1'b0;
    end else begin
      if (rd_cmd) fine_code <= fine_field;
      cfg_err <= cfg_err | hc_reserved;
    end
  end
endmodule

// File: rtl/ddr_rd_gate_chk.sv
module ddr_rd_gate_chk #(
  parameter int CL_W         = 4,
  parameter int HC_W         = 4,
  parameter int FINE_W       = 7,
  parameter int HC_LSB       = 24,
  parameter int FINE_LSB     = 16,
  parameter int HC_LEGAL_MAX = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_cmd,
  input logic [CL_W-1:0]   cas_lat,
  input logic [31:0]       gate_ctrl,
  input logic              gate_even,
  input logic              gate_odd,
  input logic [FINE_W-1:0] fine_code,
  input logic              cfg_err
);
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);

  p_reserved_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (int'(gate_ctrl[HC_LSB +: HC_W]) > HC_LEGAL_MAX) |=> cfg_err);

  p_fine_capture_r7: assert property (@(posedge clk) disable iff (rst)
    rd_cmd |=> (fine_code == $past(gate_ctrl[FINE_LSB +: FINE_W])));

  p_fine_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_cmd |=> $stable(fine_code));

  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (!gate_even && !gate_odd && fine_code == '0 && !cfg_err));

  // cas_lat only shapes the window timing, covered by the bench model
  logic unused_cl;
  assign unused_cl = ^cas_lat;
endmodule

bind ddr_rd_gate_timer ddr_rd_gate_chk #(
  .CL_W(CL_W), .HC_W(HC_W), .FINE_W(FINE_W), .HC_LSB(HC_LSB),
  .FINE_LSB(FINE_LSB), .HC_LEGAL_MAX(HC_LEGAL_MAX)
) u_chk (
  .clk(clk), .rst(rst), .rd_cmd(rd_cmd), .cas_lat(cas_lat),
  .gate_ctrl(gate_ctrl), .gate_even(gate_even), .gate_odd(gate_odd),
  .fine_code(fine_code), .cfg_err(cfg_err)
);

// File: tb/sim_ddr_rd_gate_timer.sv
module sim_ddr_rd_gate_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_cmd = 1'b0;
  logic [3:0]  cas_lat = 4'd5;
  logic [31:0] gate_ctrl = 32'h0;
  logic        gate_even, gate_odd, cfg_err;
  logic [6:0]  fine_code;

  int    n_chk = 0;
  int    n_bad = 0;
  int    edge_n = 0;
  int    starts[$];
  logic  e_err = 1'b0;
  logic [6:0] e_fine = 7'd0;
  string tag = "R8 reset";

  always #2 clk = ~clk;  // 250 MHz

  ddr_rd_gate_timer u0 (
    .clk(clk), .rst(rst), .rd_cmd(rd_cmd), .cas_lat(cas_lat),
    .gate_ctrl(gate_ctrl), .gate_even(gate_even), .gate_odd(gate_odd),
    .fine_code(fine_code), .cfg_err(cfg_err)
  );

  // First gated half-cycle slot from R2/R4/R10.
  function automatic int first_slot(input logic [3:0] cl, input logic [31:0] w);
    int b = (cl == 0) ? 0 : int'(cl) - 1;
    int h = (w[27:24] > 4'd13) ? 13 : int'(w[27:24]);
    return 2 * b + h;
  endfunction

  // R3/R6: slot enabled if inside any window of 8 slots.
  function automatic logic slot_on(input int slot);
    foreach (starts[i]) if (slot >= starts[i] && slot < starts[i] + 8) return 1'b1;
    return 1'b0;
  endfunction

  task automatic cmp(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, edge_n);
    end
  endtask

  task automatic step(input logic r, input logic [3:0] cl, input logic [31:0] w,
                      input logic rs);
    @(negedge clk);
    cmp({tag, " gate_even"}, int'(gate_even), int'(slot_on(2 * edge_n)));
    cmp({tag, " gate_odd"},  int'(gate_odd),  int'(slot_on(2 * edge_n + 1)));
    cmp("R7 fine_code", int'(fine_code), int'(e_fine));
    cmp("R5 cfg_err",   int'(cfg_err),   int'(e_err));
    rd_cmd = r; cas_lat = cl; gate_ctrl = w; rst = rs;
    edge_n++;
    if (rs) begin
      starts.delete(); e_err = 1'b0; e_fine = 7'd0;
    end else begin
      if (w[27:24] > 4'd13) e_err = 1'b1;
      if (r) begin
        starts.push_back(2 * edge_n + first_slot(cl, w));
        e_fine = w[22:16];
      end
    end
  endtask

  function automatic logic [31:0] word(input int hc, input int fine, input logic [31:0] junk);
    logic [31:0] v = junk;
    v[27:24] = 4'(hc);
    v[22:16] = 7'(fine);
    return v;
  endfunction

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(1'b0, cas_lat, gate_ctrl, 1'b0);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R8: reset state
    step(1'b0, 4'd5, 32'h0, 1'b1);
    step(1'b0, 4'd5, 32'h0, 1'b0);
    idle(2);
    // R2/R1: single read, odd half-cycle count, junk in unused bits
    tag = "R2 single";
    step(1'b1, 4'd6, word(5, 7'h2A, 32'hA0A5_FFFF), 1'b0);
    idle(26);
    // R3: even count, window length
    tag = "R3 burst";
    step(1'b1, 4'd8, word(12, 7'h7F, 32'h0), 1'b0);
    idle(26);
    // R10: lowest CAS latencies
    tag = "R10 low CL";
    step(1'b1, 4'd0, word(0, 7'h01, 32'h0), 1'b0);
    idle(6);
    step(1'b1, 4'd1, word(1, 7'h02, 32'h0), 1'b0);
    idle(8);
    // R6: back-to-back and overlapping reads
    tag = "R6 b2b";
    step(1'b1, 4'd5, word(0, 7'h10, 32'h0), 1'b0);
    step(1'b1, 4'd5, word(3, 7'h11, 32'h0), 1'b0);
    step(1'b1, 4'd7, word(1, 7'h12, 32'h0), 1'b0);
    step(1'b1, 4'd4, word(13, 7'h13, 32'h0), 1'b0);
    idle(26);
    // R9: config churn without reads
    tag = "R9 no read";
    for (int i = 0; i < 20; i++) step(1'b0, 4'($urandom), word(i % 14, i, $urandom), 1'b0);
    idle(4);
    // R8: reset while windows are pending
    tag = "R8 mid reset";
    step(1'b1, 4'd9, word(6, 7'h33, 32'h0), 1'b0);
    idle(3);
    step(1'b0, 4'd9, word(6, 7'h33, 32'h0), 1'b1);
    idle(20);
    // R4/R5: reserved counts clamp and raise the sticky flag
    tag = "R4 reserved";
    step(1'b1, 4'd3, word(15, 7'h44, 32'h0), 1'b0);
    step(1'b0, 4'd3, word(2, 7'h44, 32'h0), 1'b0);
    idle(12);
    step(1'b1, 4'd10, word(14, 7'h45, 32'h0), 1'b0);
    idle(30);
    step(1'b0, 4'd5, 32'h0, 1'b1);
    idle(2);
    // Random mix
    tag = "R2 random";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w = $urandom;
      if ($urandom % 16 != 0) w[27:24] = 4'($urandom % 14);
      step(($urandom % 3) == 0, 4'($urandom), w, ($urandom % 400) == 0);
    end
    idle(28);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule